// File: doc/BRIEF.md
# Interrupt Event Mask Controller

This block collects single-cycle event pulses from thirteen internal sources of a network controller (frame and buffer completion in both directions, management transfer done, graceful stop done, and several error conditions) into a 32-bit event register. A 32-bit mask register selects which events may reach the interrupt outputs. Each of the thirteen interrupt lines is tied to one fixed event bit and is high while that bit is both pending and enabled.

Software uses a simple register port. A write to the event register clears the bits written as one, and a write to the mask register replaces it. Reads return either register at once. Every cycle the enabled set is compared with the state recorded on the lines, and only the lines whose value differs are updated. A line therefore follows its event and mask with one cycle of delay.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset the event register, the mask register and all thirteen lines read as zero.
- R2: A pulse on `evtSet[i]` sets the event bit tied to line i on the next clock edge. The ties are: line 0 bit 27, line 1 bit 26, line 2 bit 19, line 3 bit 20, line 4 bit 25, line 5 bit 24, line 6 bit 23, line 7 bit 21, line 8 bit 31, line 9 bit 28, line 10 bit 22, line 11 bit 29, line 12 bit 30.
- R3: A write to address 0 clears every event bit that is 1 in the write data. Bits written as 0 keep their value.
- R4: A write to address 1 replaces all 32 mask bits. Address 1 reads the mask back unchanged.
- R5: Line i is high one cycle after the event bit tied to it (see R2) and the same mask bit are both 1, and it is low one cycle after either of them is 0.
- R6: When an event pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R7: Event bits 18:0 always read as zero.
- R8: Writes to addresses 2 and 3 change neither register, and those addresses read as zero.
- R9: A line changes only in a cycle where its enabled state differs from the value it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 event, 1 mask) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| evtSet | input | 13 | Event pulses, one per line, in line order |
| irqLine | output | 13 | Interrupt lines |

## Verification
A source pulse and a clearing write from software can land on the same event bit in the same cycle. The bench provokes this by driving `evtSet` for one line together with an all-ones write to address 0. It then expects that bit still set and every other bit cleared, and it expects the matching line to stay high.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_LINES = 13;
  localparam int EVT_LOW   = 19;
  localparam int ADDR_W    = 2;

  typedef struct packed {
    logic clrEvt;
    logic ldMask;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    RD_EVENT = 2'd0,
    RD_MASK  = 2'd1,
    RD_ZERO  = 2'd2
  } rdSel_t;

  // Fixed tie from interrupt line index to event bit position.
  function automatic int lineBit(input int idx);
    case (idx)
      0:       lineBit = 27;
      1:       lineBit = 26;
      2:       lineBit = 19;
      3:       lineBit = 20;
      4:       lineBit = 25;
      5:       lineBit = 24;
      6:       lineBit = 23;
      7:       lineBit = 21;
      8:       lineBit = 31;
      9:       lineBit = 28;
      10:      lineBit = 22;
      11:      lineBit = 29;
      default: lineBit = 30;
    endcase
  endfunction
endpackage

// File: rtl/irq_evt_regctl.sv
module irq_evt_regctl
  import irq_evt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  output ctlStrobe_t    strobe,
  output rdSel_t        rdSel
);
  localparam logic [AW-1:0] ADDR_EVT  = AW'(0);
  localparam logic [AW-1:0] ADDR_MASK = AW'(1);

  always_comb begin
    strobe        = '0;
    strobe.clrEvt = wrEn && (addr == ADDR_EVT);
    strobe.ldMask = wrEn && (addr == ADDR_MASK);
  end

  always_comb begin
    case (addr)
      ADDR_EVT:  rdSel = RD_EVENT;
      ADDR_MASK: rdSel = RD_MASK;
      default:   rdSel = RD_ZERO;
    endcase
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrEvt, strobe.ldMask}));

  // R8
  stray_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr != ADDR_EVT && addr != ADDR_MASK) |-> (strobe == '0));
endmodule

// File: rtl/irq_evt_datapath.sv
module irq_evt_datapath
  import irq_evt_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NL = NUM_LINES,
  parameter int LB = EVT_LOW
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  rdSel_t        rdSel,
  input  logic [DW-1:0] wrData,
  input  logic [NL-1:0] evtSet,
  output logic [DW-1:0] rdData,
  output logic [NL-1:0] lineOut
);
  localparam int HW = DW - LB;

  logic [DW-1:0] maskReg;
  logic [HW-1:0] evtHigh;
  logic [DW-1:0] evtWord;
  logic [DW-1:0] setWord;
  logic [NL-1:0] activeVec;
  logic [NL-1:0] lineState;
  logic [NL-1:0] changeVec;

  // Spread line-ordered pulses onto their event bit positions.
  always_comb begin
    setWord = '0;
    for (int k = 0; k < NL; k++) begin
      setWord[lineBit(k)] = evtSet[k];
    end
  end

  assign evtWord = {evtHigh, {LB{1'b0}}};

  // Event register: clear-by-one first, then sets override.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtHigh <= '0;
    end else begin
      evtHigh <= (evtHigh & ~(strobe.clrEvt ? wrData[DW-1:LB] : {HW{1'b0}}))
                 | setWord[DW-1:LB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
    end else if (strobe.ldMask) begin
      maskReg <= wrData;
    end
  end

  always_comb begin
    case (rdSel)
      RD_EVENT: rdData = evtWord;
      RD_MASK:  rdData = maskReg;
      default:  rdData = '0;
    endcase
  end

  assign changeVec = activeVec ^ lineState;

  generate
    for (genvar g = 0; g < NL; g++) begin : gLine
      localparam int BP = lineBit(g);
      assign activeVec[g] = evtWord[BP] & maskReg[BP];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          lineState[g] <= 1'b0;
        end else if (changeVec[g]) begin
          lineState[g] <= activeVec[g];
        end
      end

      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        evtSet[g] |=> evtWord[BP]);

      // R9
      line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (lineState[g] == activeVec[g]) |=> $stable(lineState[g]));
    end
  endgenerate

  assign lineOut = lineState;

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldMask |=> (maskReg == $past(wrData)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrEvt && evtSet == '0) |=> ((evtWord & $past(wrData)) == '0));

  // R3
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrEvt && evtSet == '0) |=> $stable(evtWord));

  // R7
  low_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == RD_EVENT) |-> (rdData[LB-1:0] == '0));
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_LINES-1:0] evtSet,
  output logic [NUM_LINES-1:0] irqLine
);
  ctlStrobe_t strobe;
  rdSel_t     rdSel;

  irq_evt_regctl #(.AW(ADDR_W)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  irq_evt_datapath #(.DW(DATA_W), .NL(NUM_LINES), .LB(EVT_LOW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .evtSet  (evtSet),
    .rdData  (regRdData),
    .lineOut (irqLine)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (irqLine == '0));
endmodule

// File: tb/sim_irq_evt_ctrl.sv
module sim_irq_evt_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [12:0] evtSet = '0;
  logic [12:0] irqLine;

  int checks = 0;
  int fails = 0;
  logic [31:0] expEvt;
  logic [31:0] expMask;

  always #10 clk = ~clk;

  irq_evt_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtSet(evtSet), .irqLine(irqLine)
  );

  function automatic int bitOf(input int k);
    int t [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return t[k];
  endfunction

  function automatic logic [12:0] linesFor(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r = '0;
    for (int k = 0; k < 13; k++) r[k] = e[bitOf(k)] & m[bitOf(k)];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [12:0] v);
    evtSet = v;
    @(negedge clk);
    evtSet = '0;
  endtask

  task automatic checkState(input string req);
    logic [31:0] d;
    readReg(2'd0, d); check({req, " event"}, d, expEvt);
    readReg(2'd1, d); check({req, " mask"}, d, expMask);
    @(negedge clk);
    check({req, " lines"}, {19'd0, irqLine}, {19'd0, linesFor(expEvt, expMask)});
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expEvt = '0; expMask = '0;
    // R1 reset state
    checkState("R1");

    // R4 mask replace, several patterns
    for (int p = 0; p < 4; p++) begin
      expMask = 32'hA5C3_0F17 ^ (32'h1111_1111 << p);
      writeReg(2'd1, expMask);
      checkState("R4");
    end
    expMask = 32'hFFFF_FFFF;
    writeReg(2'd1, expMask);

    // R2/R5/R3 per-line sweep
    for (int i = 0; i < 13; i++) begin
      pulse(13'(1) << i);
      expEvt = 32'(1) << bitOf(i);
      checkState("R2 R5");
      writeReg(2'd0, expEvt);
      expEvt = '0;
      checkState("R3");
    end

    // R5 mask sweep with all events pending
    pulse('1);
    for (int i = 0; i < 13; i++) expEvt[bitOf(i)] = 1'b1;
    for (int i = 0; i < 13; i++) begin
      expMask = 32'(1) << bitOf(i);
      writeReg(2'd1, expMask);
      checkState("R5 one-hot");
      check("R5 line", {19'd0, irqLine}, {19'd0, 13'(1) << i});
    end
    expMask = 32'h0007_FFFF;
    writeReg(2'd1, expMask);
    checkState("R5 low mask");

    // R7 low event bits zero
    readReg(2'd0, d);
    check("R7", d & 32'h0007_FFFF, 32'h0);

    // R3 partial clears, zero-write keeps
    expMask = 32'hFFFF_FFFF;
    writeReg(2'd1, expMask);
    writeReg(2'd0, 32'h0);
    checkState("R3 zero write");
    writeReg(2'd0, 32'h5500_0000);
    expEvt &= ~32'h5500_0000;
    checkState("R3 partial");
    writeReg(2'd0, 32'h0028_0000);
    expEvt &= ~32'h0028_0000;
    checkState("R3 partial2");

    // R6 set and clear together
    for (int i = 0; i < 13; i += 4) begin
      evtSet = 13'(1) << i;
      writeReg(2'd0, 32'hFFFF_FFFF);
      evtSet = '0;
      expEvt = 32'(1) << bitOf(i);
      checkState("R6");
      check("R6 line", {19'd0, irqLine}, {19'd0, 13'(1) << i});
    end

    // R8 stray addresses
    for (int a = 2; a < 4; a++) begin
      writeReg(2'(a), 32'hFFFF_FFFF);
      readReg(2'(a), d);
      check("R8 read", d, 32'h0);
      checkState("R8");
    end

    // R9 lines hold while nothing changes
    d = {19'd0, irqLine};
    repeat (5) @(negedge clk);
    check("R9", {19'd0, irqLine}, d);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule